// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the status byte of a serial flash device and decides whether a decoded write-status command may change it. Two things can refuse the change. The write-enable latch has to be set first. A lock-down bit in the register can also freeze the register, but only while the hardware write-protect pin is held low. When that pin is high the lock-down bit has no effect.

The same byte carries a busy flag, which an operation engine sets and clears while software polls it. It also carries a four-bit block-protection field. That field is copied out on its own port for the logic that protects the memory array. Every field is a flop, and each command takes effect one clock after the cycle in which it is presented.

Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 2..5 block protection (bit 2 is the field's least significant bit), bit 6 reserved and read as 0, bit 7 lock-down.

Top module: `sr_status_ctrl`

## Requirements
- R1: In the cycle after synchronous reset, `status_q` reads 8'h3C: busy 0, write-enable latch 0, all protection bits 1, lock-down 0.
- R2: A `wren_cmd` pulse makes bit 1 of `status_q` read 1 in the next cycle.
- R3: A `wrsr_cmd` presented while `wp_n` is 0 and bit 7 is 1 leaves bits 7..1 of `status_q` unchanged.
- R4: A `wrsr_cmd` presented while `wp_n` is 0, bit 7 is 0 and bit 1 is 1 loads bits 5..2 and bit 7 from `wrsr_data` in the next cycle.
- R5: A `wrsr_cmd` presented while `wp_n` is 1 and bit 1 is 1 loads bits 5..2 and bit 7 from `wrsr_data`, whatever bit 7 held before.
- R6: A `wrsr_cmd` presented while bit 1 is 0 has no effect on `status_q`.
- R7: An accepted write clears bit 1. Bits 0, 1 and 6 of `wrsr_data` are never copied, and bit 6 of `status_q` always reads 0.
- R8: `busy_set` makes bit 0 read 1 in the next cycle and `busy_clr` makes it read 0. When both are high, set wins.
- R9: `bp_q` always equals bits 5..2 of `status_q`.
- R10: When `wren_cmd` and an accepted `wrsr_cmd` arrive in the same cycle, bit 1 reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_cmd | input | 1 | Decoded write-enable command, one-cycle pulse |
| wrsr_cmd | input | 1 | Decoded write-status command, one-cycle pulse |
| wrsr_data | input | 8 | Data byte that goes with `wrsr_cmd` |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_set | input | 1 | Operation engine starts an internal write |
| busy_clr | input | 1 | Operation engine finishes an internal write |
| status_q | output | 8 | Status byte for reads |
| bp_q | output | BP_W (4) | Block-protection field for the array-protection logic |

## Verification
The gate reduces to a single accept term built from three state bits (write-enable latch, lock-down, pin). Any wrong term therefore shows at the ports one cycle after the command, as protection bits that moved when they should have held, or held when they should have moved. The bench sweeps every combination of pin level, lock-down value and latch value against all 256 data bytes. Each result is compared with a value the bench computes from the rules, so a wrong latch update or a wrong copy of a reserved bit appears within one cycle. Busy priority and the case where write-enable coincides with an accepted write are checked directly.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W     = 8;
  localparam int BUSY_POS = 0;
  localparam int WEL_POS  = 1;
  localparam int BP_LSB   = 2;
  localparam int BPL_POS  = 7;
endpackage

// File: rtl/sr_wp_gate.sv
module sr_wp_gate (
  input  logic wrsr_cmd,
  input  logic wel,
  input  logic wp_n,
  input  logic bpl,
  output logic accept
);
  logic pin_allows;

  always_comb begin
    pin_allows = wp_n | ~bpl;
    accept     = wrsr_cmd & wel & pin_allows;
  end
endmodule

// File: rtl/sr_flag_ctrl.sv
module sr_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wren_cmd,
  input  logic wr_accept,
  input  logic busy_set,
  input  logic busy_clr,
  output logic busy_q,
  output logic wel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      if (busy_set)      busy_q <= 1'b1;
      else if (busy_clr) busy_q <= 1'b0;
      if (wren_cmd)       wel_q <= 1'b1;
      else if (wr_accept) wel_q <= 1'b0;
    end
  end

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    busy_set |=> busy_q); // R8
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
    (busy_clr && !busy_set) |=> !busy_q); // R8
  AST_WREN_SETS: assert property (@(posedge clk) disable iff (rst)
    wren_cmd |=> wel_q); // R2
endmodule

// File: rtl/sr_prot_reg.sv
module sr_prot_reg #(
  parameter int BP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BP_W-1:0] bp_d,
  input  logic            bpl_d,
  output logic [BP_W-1:0] bp_q,
  output logic            bpl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q  <= '1;
      bpl_q <= 1'b0;
    end else if (load) begin
      bp_q  <= bp_d;
      bpl_q <= bpl_d;
    end
  end

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(bp_q) && $stable(bpl_q))); // R6
endmodule

// File: rtl/sr_status_ctrl.sv
module sr_status_ctrl #(
  parameter int BP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wren_cmd,
  input  logic                   wrsr_cmd,
  input  logic [sr_pkg::SR_W-1:0] wrsr_data,
  input  logic                   wp_n,
  input  logic                   busy_set,
  input  logic                   busy_clr,
  output logic [sr_pkg::SR_W-1:0] status_q,
  output logic [BP_W-1:0]        bp_q
);
  import sr_pkg::*;

  localparam logic [SR_W-1:0] BP_MASK    = SR_W'(((1 << BP_W) - 1) << BP_LSB);
  localparam logic [SR_W-1:0] WRITE_MASK = BP_MASK | SR_W'(1 << BPL_POS);
  localparam logic [SR_W-1:0] RST_VAL    = BP_MASK;

  logic busy, wel, bpl, accept;
  logic [BP_W-1:0] bp;
  logic data_spare_unused;

  assign data_spare_unused = ^(wrsr_data & ~WRITE_MASK);

  sr_wp_gate gate_i (
    .wrsr_cmd (wrsr_cmd),
    .wel      (wel),
    .wp_n     (wp_n),
    .bpl      (bpl),
    .accept   (accept)
  );

  sr_flag_ctrl flags_i (
    .clk       (clk),
    .rst       (rst),
    .wren_cmd  (wren_cmd),
    .wr_accept (accept),
    .busy_set  (busy_set),
    .busy_clr  (busy_clr),
    .busy_q    (busy),
    .wel_q     (wel)
  );

  sr_prot_reg #(.BP_W(BP_W)) prot_i (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .bp_d  (wrsr_data[BP_LSB +: BP_W]),
    .bpl_d (wrsr_data[BPL_POS]),
    .bp_q  (bp),
    .bpl_q (bpl)
  );

  always_comb begin
    status_q                  = '0;
    status_q[BUSY_POS]        = busy;
    status_q[WEL_POS]         = wel;
    status_q[BP_LSB +: BP_W]  = bp;
    status_q[BPL_POS]         = bpl;
    bp_q                      = bp;
  end

  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (status_q == RST_VAL)); // R1
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (wrsr_cmd && !wp_n && status_q[BPL_POS] && !wren_cmd) |=> $stable(status_q[SR_W-1:1])); // R3
  AST_NO_WEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrsr_cmd && !status_q[WEL_POS]) |=> $stable(status_q[SR_W-1:BP_LSB])); // R6
  AST_PIN_HIGH_WRITES: assert property (@(posedge clk) disable iff (rst)
    (wrsr_cmd && wp_n && status_q[WEL_POS]) |=> (bp_q == $past(wrsr_data[BP_LSB +: BP_W]))); // R5
  AST_ACCEPT_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
    (wrsr_cmd && wp_n && status_q[WEL_POS] && !wren_cmd) |=> !status_q[WEL_POS]); // R7
endmodule

// File: tb/sr_status_ctrl_tb_top.sv
module sr_status_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wren_cmd = 1'b0, wrsr_cmd = 1'b0, wp_n = 1'b1;
  logic busy_set = 1'b0, busy_clr = 1'b0;
  logic [7:0] wrsr_data = 8'h00;
  logic [7:0] status_q;
  logic [3:0] bp_q;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sr_status_ctrl dut_i (
    .clk(clk), .rst(rst), .wren_cmd(wren_cmd), .wrsr_cmd(wrsr_cmd),
    .wrsr_data(wrsr_data), .wp_n(wp_n), .busy_set(busy_set),
    .busy_clr(busy_clr), .status_q(status_q), .bp_q(bp_q)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_wren();
    wren_cmd = 1'b1;
    @(negedge clk);
    wren_cmd = 1'b0;
  endtask

  task automatic pulse_wrsr(input logic [7:0] d);
    wrsr_cmd = 1'b1;
    wrsr_data = d;
    @(negedge clk);
    wrsr_cmd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] pre, exp;
    bit acc;
    @(negedge clk);
    do_reset();
    chk("R1 reset status", status_q, 8'h3C);
    chk("R9 reset bp", {4'h0, bp_q}, 8'h0F);

    pulse_wren();
    chk("R2 wren sets latch", status_q, 8'h3E);

    // Sweep: pin level x lock-down x latch x every data byte (R3..R7, R9)
    for (int wp = 0; wp < 2; wp++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int wl = 0; wl < 2; wl++) begin
          for (int d = 0; d < 256; d++) begin
            do_reset();
            if (lk == 1) begin
              wp_n = 1'b1;
              pulse_wren();
              pulse_wrsr(8'hBC);
            end
            if (wl == 1) pulse_wren();
            wp_n = wp[0];
            pre = {lk[0], 1'b0, 4'hF, wl[0], 1'b0};
            acc = (wl == 1) && ((wp == 1) || (lk == 0));
            pulse_wrsr(d[7:0]);
            exp = acc ? {d[7], 1'b0, d[5:2], 2'b00} : pre;
            if (!acc && wl == 1 && wp == 0 && lk == 1)
              chk("R3 locked write rejected", status_q, exp);
            else if (wl == 0)
              chk("R6 write without latch ignored", status_q, exp);
            else if (wp == 1)
              chk("R5 pin high write accepted", status_q, exp);
            else
              chk("R4 unlocked write accepted", status_q, exp);
            if (acc) chk("R7 latch cleared, spare bits not copied", {status_q[6], status_q[1:0]}, 8'h00);
            chk("R9 bp port tracks status", {4'h0, bp_q}, {4'h0, status_q[5:2]});
          end
        end
      end
    end

    do_reset();
    wp_n = 1'b1;
    busy_set = 1'b1;
    @(negedge clk);
    busy_set = 1'b0;
    chk("R8 busy set", status_q, 8'h3D);
    busy_clr = 1'b1;
    @(negedge clk);
    busy_clr = 1'b0;
    chk("R8 busy clear", status_q, 8'h3C);
    busy_set = 1'b1;
    busy_clr = 1'b1;
    @(negedge clk);
    busy_set = 1'b0;
    busy_clr = 1'b0;
    chk("R8 set wins over clear", status_q, 8'h3D);
    pulse_wren();
    pulse_wrsr(8'h03);
    chk("R7 busy not written by data", status_q, 8'h01);

    do_reset();
    pulse_wren();
    wren_cmd = 1'b1;
    pulse_wrsr(8'h94);
    wren_cmd = 1'b0;
    chk("R10 wren with accepted write", status_q, 8'h96);
    chk("R9 bp after write", {4'h0, bp_q}, 8'h05);

    finish_run();
  end
endmodule